// File: doc/BRIEF.md
# Audio Clock Monitor and Recovery Sequencer

This block supervises the three serial-audio clocks that an external source drives into a slave-mode audio converter: the master clock, the bit clock and the frame (left/right) clock. All three are sampled as plain inputs into a fixed, free-running reference clock domain. A frame is the interval between two rising edges of the frame clock. For each frame the block counts master-clock rising edges, bit-clock rising edges and reference cycles. A separate timer for each input detects a clock that has stopped.

On any clock fault the output is muted in the very next cycle, with no volume ramp-down, and the sequencer parks in a waiting state. It leaves that state only after a run of consecutive clean frames. It then pulses a divider-reload strobe together with the detected sample-rate family and restores the audio through a linear fade-in of one gain step per frame. A fault at any point, the fade-in included, drops straight back to the muted waiting state. The sample-rate family (44.1 kHz-related or 48 kHz-related) comes from the frame period in reference cycles, because the clock ratios are the same for both families.

Top module: `audio_clk_guard`

## Requirements
- R1: After reset the block is in the waiting state: `mute`=1, `gain`=0, `clk_fault`=1, `cfg_load`=0.
- R2: If any of master, bit or frame clock shows no rising edge for MISS_TIMEOUT reference cycles, a fault is raised.
- R3: A frame whose bit-clock rising-edge count differs from BCK_RATIO raises a fault.
- R4: A frame whose master-clock rising-edge count differs from MCLK_RATIO raises a fault.
- R5: On a fault in any state, `gain` becomes 0 and `mute` becomes 1 in the next cycle, with no intermediate gain values, and `clk_fault`=1 while the sequencer waits.
- R6: The waiting state is left only after LOCK_FRAMES consecutive clean frames of one family with no missing clock. `cfg_load` is then high for exactly one cycle, while `mute` is still 1.
- R7: `rate_family` is 0 (44.1 kHz family) when the measured frame period exceeds FAMILY_SPLIT reference cycles and 1 (48 kHz family) otherwise. It is latched at the `cfg_load` cycle.
- R8: After `cfg_load`, `mute` drops and `gain` starts at 0 and rises by 2^GAIN_W/RAMP_STEPS at each frame boundary until it reaches 2^GAIN_W, where it holds. `gain` is nonzero only while `mute`=0.
- R9: A fault during fade-in aborts the ramp: `gain` goes straight to 0 with `mute`=1.
- R10: During fade-in or normal running, a clean frame whose family differs from the latched `rate_family` is a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_in | input | 1 | Master clock, sampled asynchronously |
| bclk_in | input | 1 | Bit clock, sampled asynchronously |
| lrclk_in | input | 1 | Frame clock, sampled asynchronously; a rising edge starts a frame |
| mute | output | 1 | Hard mute to the audio path |
| gain | output | GAIN_W+1 | Fade gain, 0 to 2^GAIN_W |
| rate_family | output | 1 | Latched family: 0 = 44.1 kHz, 1 = 48 kHz |
| cfg_load | output | 1 | One-cycle divider reload strobe |
| clk_fault | output | 1 | High while waiting for valid clocks |

## Verification
The bench builds the block with BCK_RATIO=4, MCLK_RATIO=8, MISS_TIMEOUT=64, FAMILY_SPLIT=40, LOCK_FRAMES=4, GAIN_W=4 and RAMP_STEPS=4. With these values a frame lasts 48 or 32 reference cycles for the two families, and a whole lock, ramp and fault cycle fits in a few hundred cycles. That makes it practical to sweep every fault kind (each clock stopped, wrong bit ratio, wrong master ratio, family switch) against both families and against injection both mid-ramp and at full gain. For each case the bench derives the detection limit, the lock window, the ramp step and the step interval from the frame period. A continuous monitor rejects any ramp-down or any nonzero gain while muted.

// File: rtl/acg_pkg.sv
package acg_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_LOAD = 2'd1,
        ST_FADE = 2'd2,
        ST_RUN  = 2'd3
    } acg_state_e;

    localparam int unsigned CLK_NUM = 3;
    localparam int unsigned IDX_MCLK = 0;
    localparam int unsigned IDX_BCLK = 1;
    localparam int unsigned IDX_LRCLK = 2;

endpackage

// File: rtl/acg_edge_sync.sv
module acg_edge_sync #(
    parameter int unsigned NUM = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] raw,
    output logic [NUM-1:0] rise
);
    typedef struct packed {
        logic [NUM-1:0] s1;
        logic [NUM-1:0] s2;
        logic [NUM-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = raw;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    for (genvar i = 0; i < NUM; i++) begin : g_rise
        assign rise[i] = sync_q.s2[i] & ~sync_q.s3[i];
    end

endmodule

// File: rtl/acg_frame_meter.sv
module acg_frame_meter
    import acg_pkg::*;
#(
    parameter int unsigned BCK_RATIO    = 64,
    parameter int unsigned MCLK_RATIO   = 512,
    parameter int unsigned MISS_TIMEOUT = 4096,
    parameter int unsigned FAMILY_SPLIT = 2175
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CLK_NUM-1:0] rise,
    output logic               tick,
    output logic               ratio_ok,
    output logic               family,
    output logic               missing
);
    localparam int unsigned BW = $clog2(2*BCK_RATIO + 1);
    localparam int unsigned MW = $clog2(2*MCLK_RATIO + 1);
    localparam int unsigned PW = $clog2(2*FAMILY_SPLIT + 1);
    localparam int unsigned TW = $clog2(MISS_TIMEOUT + 1);
    localparam logic [BW-1:0] BMAX = '1;
    localparam logic [MW-1:0] MMAX = '1;
    localparam logic [PW-1:0] PMAX = '1;
    localparam logic [TW-1:0] TLIM = TW'(MISS_TIMEOUT);

    typedef struct packed {
        logic [BW-1:0]              bcnt;
        logic [MW-1:0]              mcnt;
        logic [PW-1:0]              per;
        logic [CLK_NUM-1:0][TW-1:0] tmr;
        logic                       tick;
        logic                       ok;
        logic                       fam;
        logic                       missing;
    } meter_t;

    meter_t m_d, m_q;
    logic [BW-1:0] bsum;
    logic [MW-1:0] msum;
    logic [PW-1:0] psum;

    always_comb begin
        m_d      = m_q;
        m_d.tick = 1'b0;
        bsum = (m_q.bcnt == BMAX) ? BMAX : m_q.bcnt + BW'(rise[IDX_BCLK]);
        msum = (m_q.mcnt == MMAX) ? MMAX : m_q.mcnt + MW'(rise[IDX_MCLK]);
        psum = (m_q.per  == PMAX) ? PMAX : m_q.per + PW'(1);

        m_d.missing = 1'b0;
        for (int i = 0; i < CLK_NUM; i++) begin
            if (rise[i])                m_d.tmr[i] = '0;
            else if (m_q.tmr[i] != TLIM) m_d.tmr[i] = m_q.tmr[i] + TW'(1);
            if (m_d.tmr[i] == TLIM)     m_d.missing = 1'b1;
        end

        if (rise[IDX_LRCLK]) begin
            m_d.tick = 1'b1;
            m_d.ok   = (bsum == BW'(BCK_RATIO)) && (msum == MW'(MCLK_RATIO));
            m_d.fam  = (psum > PW'(FAMILY_SPLIT)) ? 1'b0 : 1'b1;
            m_d.bcnt = '0;
            m_d.mcnt = '0;
            m_d.per  = '0;
        end else begin
            m_d.bcnt = bsum;
            m_d.mcnt = msum;
            m_d.per  = psum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign tick     = m_q.tick;
    assign ratio_ok = m_q.ok;
    assign family   = m_q.fam;
    assign missing  = m_q.missing;

    // R3/R4: frame boundaries come from synchronised edges, never two in a row
    a_r3_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.tick |=> !m_q.tick);

    // R2: a clock edge restarts its own quiet-time timer
    a_r2_edge_restarts_timer: assert property (@(posedge clk) disable iff (!rst_n)
        rise[IDX_LRCLK] |=> (m_q.tmr[IDX_LRCLK] == '0));

endmodule

// File: rtl/acg_recover_fsm.sv
module acg_recover_fsm
    import acg_pkg::*;
#(
    parameter int unsigned LOCK_FRAMES = 4,
    parameter int unsigned GAIN_W      = 8,
    parameter int unsigned RAMP_STEPS  = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            ratio_ok,
    input  logic            family,
    input  logic            missing,
    output logic            mute,
    output logic [GAIN_W:0] gain,
    output logic            rate_family,
    output logic            cfg_load,
    output logic            clk_fault
);
    localparam int unsigned LW = $clog2(LOCK_FRAMES + 1);
    localparam logic [GAIN_W:0] FULL = (GAIN_W+1)'(1) << GAIN_W;
    localparam logic [GAIN_W:0] STEP = FULL / (GAIN_W+1)'(RAMP_STEPS);

    typedef struct packed {
        acg_state_e     state;
        logic [LW-1:0]  good;
        logic           last_fam;
        logic           family;
        logic [GAIN_W:0] gain;
    } seq_t;

    seq_t s_d, s_q;
    logic bad_frame;
    logic err;
    logic [LW-1:0] good_nxt;

    always_comb begin
        s_d       = s_q;
        bad_frame = missing | (tick & ~ratio_ok);
        err       = bad_frame;
        if ((s_q.state == ST_FADE) || (s_q.state == ST_RUN))
            err = bad_frame | (tick & ratio_ok & (family != s_q.family));
        good_nxt = s_q.good;

        unique case (s_q.state)
            ST_WAIT: begin
                s_d.gain = '0;
                if (bad_frame) begin
                    s_d.good = '0;
                end else if (tick) begin
                    if ((s_q.good != '0) && (family != s_q.last_fam))
                        good_nxt = LW'(1);
                    else
                        good_nxt = s_q.good + LW'(1);
                    s_d.last_fam = family;
                    if (good_nxt == LW'(LOCK_FRAMES)) begin
                        s_d.state  = ST_LOAD;
                        s_d.family = family;
                        s_d.good   = '0;
                    end else begin
                        s_d.good = good_nxt;
                    end
                end
            end
            ST_LOAD: begin
                s_d.gain  = '0;
                s_d.state = err ? ST_WAIT : ST_FADE;
            end
            ST_FADE: begin
                if (err) begin
                    s_d.state = ST_WAIT;
                    s_d.gain  = '0;
                    s_d.good  = '0;
                end else if (tick) begin
                    s_d.gain = s_q.gain + STEP;
                    if (s_q.gain + STEP == FULL) s_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (err) begin
                    s_d.state = ST_WAIT;
                    s_d.gain  = '0;
                    s_d.good  = '0;
                end
            end
            default: s_d.state = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state    <= ST_WAIT;
            s_q.good     <= '0;
            s_q.last_fam <= 1'b0;
            s_q.family   <= 1'b0;
            s_q.gain     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mute        = (s_q.state == ST_WAIT) || (s_q.state == ST_LOAD);
    assign gain        = s_q.gain;
    assign rate_family = s_q.family;
    assign cfg_load    = (s_q.state == ST_LOAD);
    assign clk_fault   = (s_q.state == ST_WAIT);

    // R5: any fault mutes in the next cycle with zero gain
    a_r5_hard_mute: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (mute && (s_q.gain == '0)));

    // R8: the only nonzero gain change is one step upward
    a_r8_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.gain != $past(s_q.gain)) && (s_q.gain != '0)) |-> (s_q.gain == $past(s_q.gain) + STEP));

    // R8: gain stays zero while muted
    a_r8_zero_when_muted: assert property (@(posedge clk) disable iff (!rst_n)
        mute |-> (s_q.gain == '0));

    // R6: reload strobe lasts one cycle and follows the waiting state
    a_r6_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !cfg_load);
    a_r6_load_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_load) |-> $past(clk_fault));

endmodule

// File: rtl/audio_clk_guard.sv
module audio_clk_guard
    import acg_pkg::*;
#(
    parameter int unsigned BCK_RATIO    = 64,
    parameter int unsigned MCLK_RATIO   = 512,
    parameter int unsigned MISS_TIMEOUT = 4096,
    parameter int unsigned FAMILY_SPLIT = 2175,
    parameter int unsigned LOCK_FRAMES  = 4,
    parameter int unsigned GAIN_W       = 8,
    parameter int unsigned RAMP_STEPS   = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mclk_in,
    input  logic            bclk_in,
    input  logic            lrclk_in,
    output logic            mute,
    output logic [GAIN_W:0] gain,
    output logic            rate_family,
    output logic            cfg_load,
    output logic            clk_fault
);
    logic [CLK_NUM-1:0] raw_clk;
    logic [CLK_NUM-1:0] clk_rise;
    logic               frm_tick;
    logic               frm_ok;
    logic               frm_fam;
    logic               clk_missing;

    assign raw_clk[IDX_MCLK]  = mclk_in;
    assign raw_clk[IDX_BCLK]  = bclk_in;
    assign raw_clk[IDX_LRCLK] = lrclk_in;

    acg_edge_sync #(.NUM(CLK_NUM)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_clk),
        .rise  (clk_rise)
    );

    acg_frame_meter #(
        .BCK_RATIO    (BCK_RATIO),
        .MCLK_RATIO   (MCLK_RATIO),
        .MISS_TIMEOUT (MISS_TIMEOUT),
        .FAMILY_SPLIT (FAMILY_SPLIT)
    ) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (clk_rise),
        .tick     (frm_tick),
        .ratio_ok (frm_ok),
        .family   (frm_fam),
        .missing  (clk_missing)
    );

    acg_recover_fsm #(
        .LOCK_FRAMES (LOCK_FRAMES),
        .GAIN_W      (GAIN_W),
        .RAMP_STEPS  (RAMP_STEPS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (frm_tick),
        .ratio_ok    (frm_ok),
        .family      (frm_fam),
        .missing     (clk_missing),
        .mute        (mute),
        .gain        (gain),
        .rate_family (rate_family),
        .cfg_load    (cfg_load),
        .clk_fault   (clk_fault)
    );

endmodule

// File: tb/audio_clk_guard_test.sv
module audio_clk_guard_test;
    localparam int BR = 4, MR = 8, TMO = 64, SPLIT = 40, LOCK = 4, GW = 4, RS = 4;
    localparam int FULL = 1 << GW;
    localparam int STEP = FULL / RS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk_in = 1'b0, bclk_in = 1'b0, lrclk_in = 1'b0;
    logic mute, rate_family, cfg_load, clk_fault;
    logic [GW:0] gain;

    int n_chk = 0, n_fail = 0, viol = 0;
    int h = 3, t = 0;
    bit en_m = 0, en_b = 0, en_l = 0, bad_b = 0, bad_m = 0, done = 0;

    always #2 clk = ~clk;

    audio_clk_guard #(.BCK_RATIO(BR), .MCLK_RATIO(MR), .MISS_TIMEOUT(TMO),
        .FAMILY_SPLIT(SPLIT), .LOCK_FRAMES(LOCK), .GAIN_W(GW), .RAMP_STEPS(RS)) uut (
        .clk(clk), .rst_n(rst_n), .mclk_in(mclk_in), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .mute(mute), .gain(gain), .rate_family(rate_family), .cfg_load(cfg_load),
        .clk_fault(clk_fault));

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // audio clock generator: frame = 16*h reference cycles
    initial begin
        forever begin
            @(negedge clk);
            t = (t + 1) % (16 * h);
            mclk_in  = en_m & (bad_m ? ((t / (2*h)) % 2 == 1) : ((t / h) % 2 == 1));
            bclk_in  = en_b & (bad_b ? ((t / h) % 2 == 1) : ((t / (2*h)) % 2 == 1));
            lrclk_in = en_l & ((t / (8*h)) % 2 == 1);
        end
    end

    // R5/R8 monitor: no ramp-down, single upward steps, no gain while muted
    initial begin
        int prev;
        prev = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (int'(gain) < prev && gain != 0) viol++;
                if (int'(gain) > prev && int'(gain) != prev + STEP) viol++;
                if (gain != 0 && mute) viol++;
            end
            prev = int'(gain);
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            report();
        end
    end

    task automatic recover(input int hh);
        int cnt, fam;
        bit seen;
        int lim;
        h = hh; t = 0; en_m = 1; en_b = 1; en_l = 1; bad_b = 0; bad_m = 0;
        cnt = 0; seen = 0; fam = -1;
        lim = (LOCK + 3) * 16 * hh + 40;
        do begin
            @(negedge clk);
            cnt++;
            if (cfg_load) begin
                seen = 1; fam = rate_family;
                check(mute == 1'b1, "R6 mute during load", mute, 1);
            end
        end while (mute && cnt <= lim);
        check(cnt >= (LOCK - 1) * 16 * hh, "R6 lock too early", cnt, (LOCK - 1) * 16 * hh);
        check(cnt <= lim, "R6 lock timeout", cnt, lim);
        check(seen, "R6 cfg_load pulse", seen, 1);
        check(fam == ((16 * hh > SPLIT) ? 0 : 1), "R7 family", fam, (16 * hh > SPLIT) ? 0 : 1);
    endtask

    task automatic run_case(input int hh, input int f, input int ph);
        int cnt, lim, incs, last, bad_iv, prev;
        string tag;
        recover(hh);
        if (ph == 1) begin
            cnt = 0;
            while (gain != STEP && cnt < 16 * hh + 20) begin @(negedge clk); cnt++; end
            check(gain == STEP, "R8 first step", gain, STEP);
        end else begin
            incs = 0; last = 0; bad_iv = 0; cnt = 0; prev = gain;
            while (gain != FULL && cnt < (RS + 1) * 16 * hh + 20) begin
                @(negedge clk); cnt++;
                if (int'(gain) != prev) begin
                    incs++;
                    if (incs > 1 && cnt - last != 16 * hh) bad_iv++;
                    last = cnt;
                end
                prev = gain;
            end
            check(incs == RS, "R8 step count", incs, RS);
            check(bad_iv == 0, "R8 step interval", bad_iv, 0);
            repeat (32 * hh) @(negedge clk);
            check(gain == FULL && !mute, "R8 hold full", gain, FULL);
        end
        case (f)
            0: begin en_m = 0; tag = "R2 mclk stop"; end
            1: begin en_b = 0; tag = "R2 bclk stop"; end
            2: begin en_l = 0; tag = "R2 lrclk stop"; end
            3: begin bad_b = 1; tag = "R3 bclk ratio"; end
            4: begin bad_m = 1; tag = "R4 mclk ratio"; end
            default: begin h = (hh == 3) ? 2 : 3; t = 0; tag = "R10 family switch"; end
        endcase
        if (ph == 1) tag = {tag, " R9 in fade"};
        lim = (f <= 2) ? TMO + 16 * hh + 12 : 2 * 16 * 3 + 12;
        cnt = 0;
        while (!(mute && gain == 0 && clk_fault) && cnt <= lim) begin @(negedge clk); cnt++; end
        check(cnt <= lim, tag, cnt, lim);
        if (f != 5) begin
            repeat (48 * hh) @(negedge clk);
            check(mute && clk_fault, "R5 stays muted", mute, 1);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mute == 1'b1, "R1 mute", mute, 1);
        check(gain == 0, "R1 gain", gain, 0);
        check(clk_fault == 1'b1, "R1 fault", clk_fault, 1);
        check(cfg_load == 1'b0, "R1 load", cfg_load, 0);
        for (int hi = 0; hi < 2; hi++)
            for (int f = 0; f < 6; f++)
                for (int ph = 1; ph <= 2; ph++)
                    run_case((hi == 0) ? 3 : 2, f, ph);
        check(viol == 0, "R5 R8 gain monitor", viol, 0);
        done = 1;
        report();
    end

endmodule